// File: doc/BRIEF.md
# Mode-configurable sum-of-products macrocell array

This block is a small programmable-logic core. Sixteen array columns feed a wired-AND plane of sixty-four product terms. Eight come from dedicated inputs and eight are feedback columns, one for each macrocell. Each of the eight macrocells owns eight of those terms and ORs some or all of them into a sum. An XOR polarity bit is applied to the sum. The result either drives the pad directly or is held in a flip-flop that drives the pad through an inverter.

A global two-bit mode sets the personality of the whole array. In registered mode, the shared pin `pin_clk` clocks every flip-flop and the shared pin `pin_oen` enables the registered outputs (active low). In complex mode, both shared pins become array inputs. They take over the feedback columns of the two outermost macrocells, and every macrocell uses one product term as its output enable. In simple mode, every term feeds the sum and there is no enable term. Feedback columns are fed from the neighbouring pad, so the two centre macrocells lose their feedback and are always driven. The fuse plane, the mode and the per-macrocell control bits are static configuration vectors.

Top module: `pld_macro_array`

## Requirements
- R1: Term t (macrocell t/8, slot t%8) is the AND of every literal whose fuse bit is 1. The bit `cfg_fuse[t*32 + 2*c + p]` selects column c, true when p=0 and complemented when p=1. Columns 0..7 are `din`, and column 8+k is the feedback of macrocell k. A term with no selected literal is 1. A term that selects both polarities of one column is 0.
- R2: `cfg_mode` codes: 2'b00 simple, 2'b01 complex, 2'b10 or 2'b11 registered.
- R3: In registered mode, a macrocell with `cfg_reg[k]`=1 ORs all eight of its terms, applies the XOR bit, and captures the result on the rising edge of `pin_clk`. The pad shows the inverted flip-flop. Its enable is `cfg_out_en[k]` AND NOT `pin_oen`.
- R4: While `rst_n` is low, every flip-flop is cleared, so registered macrocells output 1.
- R5: In complex mode, and for non-registered macrocells in registered mode, slot 0 is the output enable (ANDed with `cfg_out_en[k]`), and slots 1..7 are ORed into the sum.
- R6: Outside simple mode, a macrocell with `cfg_out_en[k]`=0 never asserts `io_oe[k]`.
- R7: In registered mode, feedback column 8+k carries the flip-flop value of a registered macrocell and `io_in[k]` otherwise. `pin_clk` and `pin_oen` never reach the array.
- R8: In complex mode, column 8 is `pin_clk`, column 15 is `pin_oen`, and column 8+k is `io_in[k]` for k=1..6. `io_in[0]` and `io_in[7]` are ignored.
- R9: In simple mode, all eight slots are summed and the enable is `cfg_out_en[k]`. Column 8 is `pin_clk` and column 15 is `pin_oen`. Columns 9..11 take `io_in[0..2]` and columns 12..14 take `io_in[5..7]`. Macrocells 3 and 4 are always enabled.
- R10: A non-registered output equals its sum XOR `cfg_xor[k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset clearing all flip-flops |
| pin_clk | input | 1 | Shared pin: common clock (registered) or array input |
| pin_oen | input | 1 | Shared pin: active-low registered enable or array input |
| din | input | 8 | Dedicated array inputs |
| io_in | input | 8 | Pad values of the macrocell pins |
| cfg_mode | input | 2 | Array personality |
| cfg_out_en | input | 8 | 0 configures the macrocell as a dedicated input |
| cfg_reg | input | 8 | Registered macrocell select (registered mode only) |
| cfg_xor | input | 8 | Sum polarity per macrocell |
| cfg_fuse | input | 2048 | AND-plane literal selections |
| io_out | output | 8 | Macrocell pad drive value |
| io_oe | output | 8 | Macrocell pad drive enable |

## Verification
Registered mode is exercised with a data term, an inverted-polarity term, and a shift between two flip-flops through a register feedback column. These separate the capture of the sum from the inverted pad path and from the feedback of register state. Toggling `pin_oen` with the data held constant isolates the common enable. Complex and simple modes are each driven with two patterns that flip the shared pins and the pads in opposite directions. This shows which physical source reaches every feedback column, and that the outermost pads (complex mode) and the centre pads (simple mode) are ignored. A macrocell set as an input in each mode, and a centre macrocell set as an input in simple mode, distinguish a forced enable from a configured one.

// File: rtl/pld_macro_array.sv
module pld_macro_array #(
  parameter int NIN = 8,
  parameter int NMC = 8,
  parameter int NPT = 8
) (
  input  logic                                 rst_n,
  input  logic                                 pin_clk,
  input  logic                                 pin_oen,
  input  logic [NIN-1:0]                       din,
  input  logic [NMC-1:0]                       io_in,
  input  logic [1:0]                           cfg_mode,
  input  logic [NMC-1:0]                       cfg_out_en,
  input  logic [NMC-1:0]                       cfg_reg,
  input  logic [NMC-1:0]                       cfg_xor,
  input  logic [NMC*NPT*2*(NIN+NMC)-1:0]       cfg_fuse,
  output logic [NMC-1:0]                       io_out,
  output logic [NMC-1:0]                       io_oe
);
  localparam int NCOL  = NIN + NMC;
  localparam int NLIT  = 2 * NCOL;
  localparam int NTERM = NMC * NPT;
  localparam int CL    = NMC/2 - 1;
  localparam int CR    = NMC/2;

  wire registered = cfg_mode[1];
  wire simple     = (cfg_mode == 2'b00);

  logic [NMC-1:0]   q, d, fb;
  logic [NCOL-1:0]  col;
  logic [NLIT-1:0]  lit;
  logic [NTERM-1:0] pt;

  assign col = {fb, din};

  genvar c, t, k;
  generate
    for (c = 0; c < NCOL; c++) begin : g_lit
      assign lit[2*c]   = col[c];
      assign lit[2*c+1] = ~col[c];
    end
    for (t = 0; t < NTERM; t++) begin : g_pt
      assign pt[t] = ~|(cfg_fuse[t*NLIT +: NLIT] & ~lit);
    end
    for (k = 0; k < NMC; k++) begin : g_mc
      wire [NPT-1:0] terms  = pt[k*NPT +: NPT];
      wire           is_reg = registered & cfg_reg[k];
      wire           pt_oe  = !simple && !is_reg;
      wire           sum    = pt_oe ? |terms[NPT-1:1] : |terms;

      assign d[k]      = sum ^ cfg_xor[k];
      assign io_out[k] = is_reg ? ~q[k] : d[k];

      if (k == CL || k == CR) begin : g_centre
        assign io_oe[k] = simple ? 1'b1 :
                          is_reg ? (cfg_out_en[k] & ~pin_oen) : (cfg_out_en[k] & terms[0]);
      end else begin : g_edge
        assign io_oe[k] = simple ? cfg_out_en[k] :
                          is_reg ? (cfg_out_en[k] & ~pin_oen) : (cfg_out_en[k] & terms[0]);
      end

      if (k == 0) begin : g_fb_first
        assign fb[k] = registered ? (cfg_reg[k] ? q[k] : io_in[k]) : pin_clk;
      end else if (k == NMC-1) begin : g_fb_last
        assign fb[k] = registered ? (cfg_reg[k] ? q[k] : io_in[k]) : pin_oen;
      end else if (k < CR) begin : g_fb_low
        assign fb[k] = registered ? (cfg_reg[k] ? q[k] : io_in[k]) :
                       simple ? io_in[k-1] : io_in[k];
      end else begin : g_fb_high
        assign fb[k] = registered ? (cfg_reg[k] ? q[k] : io_in[k]) :
                       simple ? io_in[k+1] : io_in[k];
      end
    end
  endgenerate

  always_ff @(posedge pin_clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= d;
endmodule

// File: rtl/pld_macro_array_chk.sv
module pld_macro_array_chk #(
  parameter int NMC = 8
) (
  input logic           rst_n,
  input logic           pin_clk,
  input logic           pin_oen,
  input logic [1:0]     cfg_mode,
  input logic [NMC-1:0] cfg_out_en,
  input logic [NMC-1:0] cfg_reg,
  input logic [NMC-1:0] io_out,
  input logic [NMC-1:0] io_oe
);
  always_comb begin
    if (cfg_mode != 2'b00) begin
      // R6
      input_quiet_chk: assert ((io_oe & ~cfg_out_en) == '0);
    end
    if (cfg_mode == 2'b00) begin
      // R9
      centre_on_chk: assert (io_oe[NMC/2] && io_oe[NMC/2-1]);
    end
  end

  // R3
  reg_oe_chk: assert property (@(posedge pin_clk) disable iff (!rst_n)
    (cfg_mode[1] && pin_oen) |-> ((io_oe & cfg_reg) == '0));

  // R4
  reset_high_chk: assert property (@(posedge pin_clk) disable iff (!rst_n)
    (cfg_mode[1] && !$past(rst_n)) |-> ((io_out & cfg_reg) == cfg_reg));
endmodule

bind pld_macro_array pld_macro_array_chk #(.NMC(NMC)) i_chk (
  .rst_n(rst_n), .pin_clk(pin_clk), .pin_oen(pin_oen), .cfg_mode(cfg_mode),
  .cfg_out_en(cfg_out_en), .cfg_reg(cfg_reg), .io_out(io_out), .io_oe(io_oe)
);

// File: tb/test_pld_macro_array.sv
module test_pld_macro_array;
  localparam int NL = 32;

  logic clk = 0, clk_sel = 1, p1 = 0;
  logic rst_n = 0, pin_oen = 0;
  logic [7:0] din = 0, io_in = 0;
  logic [1:0] cfg_mode = 2'b10;
  logic [7:0] cfg_out_en = 0, cfg_reg = 0, cfg_xor = 0;
  logic [2047:0] fuse = '0;
  logic [7:0] io_out, io_oe;
  wire pin_clk = clk_sel ? clk : p1;

  int checks = 0, errors = 0;
  logic [15:0] expq[$];
  string tagq[$];

  always #4 clk = ~clk;

  pld_macro_array i_pld_macro_array (
    .rst_n(rst_n), .pin_clk(pin_clk), .pin_oen(pin_oen), .din(din), .io_in(io_in),
    .cfg_mode(cfg_mode), .cfg_out_en(cfg_out_en), .cfg_reg(cfg_reg), .cfg_xor(cfg_xor),
    .cfg_fuse(fuse), .io_out(io_out), .io_oe(io_oe)
  );

  task automatic kill_all();
    for (int t = 0; t < 64; t++) begin
      fuse[t*NL +: NL] = '0;
      fuse[t*NL] = 1'b1;
      fuse[t*NL+1] = 1'b1;
    end
  endtask
  task automatic empty_term(input int t);
    fuse[t*NL +: NL] = '0;
  endtask
  task automatic set_term(input int t, input int c, input int p);
    fuse[t*NL +: NL] = '0;
    fuse[t*NL + 2*c + p] = 1'b1;
  endtask
  task automatic add_lit(input int t, input int c, input int p);
    fuse[t*NL + 2*c + p] = 1'b1;
  endtask

  task automatic apply(input logic [7:0] d, input logic [7:0] ext, input logic a, input logic b,
                       input logic [7:0] eo, input logic [7:0] eoe, input int lat, input string tag);
    @(posedge clk);
    #2;
    din = d; io_in = ext; p1 = a; pin_oen = b;
    repeat (lat) @(posedge clk);
    if (lat > 0) #2;
    expq.push_back({eo, eoe});
    tagq.push_back(tag);
    #5;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #6;
      if (expq.size() > 0) begin
        logic [15:0] e;
        string tg;
        e = expq.pop_front();
        tg = tagq.pop_front();
        checks++;
        if (io_out !== e[15:8]) begin
          errors++;
          $display("FAIL %s io_out actual %h expected %h", tg, io_out, e[15:8]);
        end
        checks++;
        if (io_oe !== e[7:0]) begin
          errors++;
          $display("FAIL %s io_oe actual %h expected %h", tg, io_oe, e[7:0]);
        end
      end
    end
  end

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // registered mode: mc0,1,2,6 registered, mc5 input
    cfg_mode = 2'b10; cfg_reg = 8'h47; cfg_xor = 8'h02; cfg_out_en = 8'hDF;
    kill_all();
    set_term(0, 0, 0);
    set_term(8, 1, 0);
    set_term(16, 8, 0);
    set_term(24, 7, 0);
    set_term(25, 2, 0); add_lit(25, 3, 0);
    empty_term(32);
    set_term(33, 12, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    expq.push_back({8'h47, 8'h57}); tagq.push_back("R4 reset state");
    #5;
    apply(8'h8D, 8'h10, 0, 0, 8'h5C, 8'h5F, 1, "R3 R1 R10 capture");
    apply(8'h02, 8'h00, 0, 0, 8'h43, 8'h57, 1, "R3 R7 shift via feedback");
    apply(8'h02, 8'h00, 0, 1, 8'h47, 8'h10, 0, "R3 R6 pin enable off");
    apply(8'h84, 8'h10, 0, 0, 8'h57, 8'h5F, 0, "R1 R5 R7 product term");

    // complex mode
    clk_sel = 0;
    cfg_reg = 8'hFF; cfg_xor = 8'h10; cfg_out_en = 8'hDF;
    kill_all();
    empty_term(0);  set_term(1, 0, 0);
    empty_term(8);  set_term(9, 8, 0);
    empty_term(16); set_term(17, 15, 1);
    empty_term(24); set_term(25, 9, 0);
    empty_term(32);
    empty_term(40);
    set_term(48, 7, 0); empty_term(49);
    empty_term(56); set_term(57, 14, 0);
    cfg_mode = 2'b01;
    apply(8'h01, 8'h43, 1, 0, 8'hDF, 8'h9F, 0, "R8 R5 R10 R2 complex a");
    apply(8'h80, 8'h81, 0, 1, 8'h50, 8'hDF, 0, "R8 R6 complex b");

    // simple mode
    cfg_xor = 8'h80; cfg_out_en = 8'hD7; cfg_reg = 8'h00;
    kill_all();
    set_term(0, 8, 0);
    set_term(15, 9, 0);
    set_term(16, 15, 0);
    set_term(24, 12, 0);
    set_term(32, 11, 0);
    set_term(48, 14, 0);
    empty_term(56);
    cfg_mode = 2'b00;
    apply(8'h00, 8'h21, 1, 0, 8'h0B, 8'hDF, 0, "R9 R10 simple a");
    apply(8'h00, 8'h9C, 0, 1, 8'h54, 8'hDF, 0, "R9 simple b");

    wait (expq.size() == 0);
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule